// File: doc/BRIEF.md
# Burst Address Generator

This block supplies the access address for each cycle of a four-beat burst. A control input picks, on every enabled clock edge, either to take a fresh base address from outside or to step an internal two-bit beat counter. Only the two least significant address bits are sequenced. Every bit above them is taken from the base address at load time and then held for the whole burst.

A static strap selects the beat order, and the block samples it only when it loads. In linear order the low bits count upward modulo four from the starting value. In interleaved order each beat is the starting value XORed with the beat number. In both orders the sequence stays inside the aligned group of four and repeats after the fourth address. When clock enable is low, the counter, the captured state and the output all hold.

The address output is driven combinationally from registered state. A load or advance therefore shows on the output in the cycle that follows the enabled edge.

Top module: `burst_addr_gen`

## Requirements
- R1: On an enabled edge with `adv` low, `addr_out` takes the value of `base_addr` from that edge and holds it until the next enabled edge.
- R2: With `order_il` low at load, each enabled edge with `adv` high adds one modulo 4 to `addr_out[1:0]`. From a start of 01 the beats are 01, 10, 11, 00.
- R3: With `order_il` high at load, beat k (k = 0..3, where 0 is the loaded beat) has `addr_out[1:0]` equal to start XOR k. From a start of 01 the beats are 01, 00, 11, 10.
- R4: The fourth advance after a load brings `addr_out` back to the loaded address. Continued advancing repeats the same four addresses.
- R5: While advancing, `addr_out[ADDR_W-1:2]` stays equal to the upper bits of the loaded base address.
- R6: With `clk_en` low, `addr_out` does not change, whatever `adv`, `base_addr` and `order_il` do.
- R7: `order_il` is sampled only on a load edge. Changing it during a burst leaves the remaining beats unchanged.
- R8: After reset, `addr_out` is zero and the order is linear until the first load.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_en | input | 1 | High lets an edge load or advance; low holds all state |
| adv | input | 1 | 0 = load `base_addr`, 1 = advance the beat counter |
| base_addr | input | ADDR_W | Starting address of a burst |
| order_il | input | 1 | 0 = linear order, 1 = interleaved order; sampled at load |
| addr_out | output | ADDR_W | Address for the current beat |

## Verification
The assertions assume that `clk_en`, `adv` and `order_il` carry known values at every rising edge after reset, and that `base_addr` is known on load edges. The bench changes every input on the falling edge only, so each value is stable around the rising edge that uses it. It also keeps every control input at a defined level from time zero. The interleaved-order property depends on the strap captured at load, not on the live pin. A strap change in the middle of a burst is therefore legal stimulus and is exercised on purpose.

// File: rtl/burst_addr_gen.sv
module burst_addr_gen #(
  parameter int ADDR_W = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clk_en,
  input  logic              adv,
  input  logic [ADDR_W-1:0] base_addr,
  input  logic              order_il,
  output logic [ADDR_W-1:0] addr_out
);
  localparam int UP_W = ADDR_W - 2;

  logic [UP_W-1:0] upper_q;
  logic [1:0]      start_q;
  logic [1:0]      beat_q;
  logic            ilv_q;
  logic [1:0]      low;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      upper_q <= '0;
      start_q <= 2'b00;
      beat_q  <= 2'b00;
      ilv_q   <= 1'b0;
    end else if (clk_en) begin
      if (!adv) begin
        upper_q <= base_addr[ADDR_W-1:2];
        start_q <= base_addr[1:0];
        beat_q  <= 2'b00;
        ilv_q   <= order_il;
      end else begin
        beat_q  <= beat_q + 2'd1;
      end
    end
  end

  assign low      = ilv_q ? (start_q ^ beat_q) : (start_q + beat_q);
  assign addr_out = {upper_q, low};

  AST_LOAD_TAKES_BASE: assert property (@(posedge clk) disable iff (!rst_n)
    clk_en && !adv |=> addr_out == $past(base_addr)); // R1
  AST_LINEAR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    clk_en && adv && !ilv_q |=> addr_out[1:0] == $past(addr_out[1:0]) + 2'd1); // R2
  AST_WRAP_TO_START: assert property (@(posedge clk) disable iff (!rst_n)
    clk_en && adv && beat_q == 2'd3 |=> addr_out[1:0] == start_q); // R4
  AST_UPPER_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    clk_en && adv |=> addr_out[ADDR_W-1:2] == $past(addr_out[ADDR_W-1:2])); // R5
  AST_ENABLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !clk_en |=> $stable(addr_out)); // R6
  AST_ORDER_LATCHED: assert property (@(posedge clk) disable iff (!rst_n)
    adv |=> $stable(ilv_q)); // R7
  AST_INTERLEAVE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    clk_en && adv && ilv_q |=> (addr_out[1:0] ^ $past(addr_out[1:0])) == ($past(beat_q) ^ ($past(beat_q) + 2'd1))); // R3
endmodule

// File: tb/burst_addr_gen_tb.sv
module burst_addr_gen_tb;
  localparam int AW = 20;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          clk_en = 1'b0;
  logic          adv = 1'b0;
  logic [AW-1:0] base_addr = '0;
  logic          order_il = 1'b0;
  logic [AW-1:0] addr_out;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  burst_addr_gen #(.ADDR_W(AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .adv(adv),
    .base_addr(base_addr), .order_il(order_il), .addr_out(addr_out)
  );

  always #5 clk = ~clk;

  function automatic logic [1:0] ref_low(input logic [1:0] s, input int k, input logic il);
    logic [1:0] kk;
    kk = k[1:0];
    return il ? (s ^ kk) : (s + kk);
  endfunction

  task automatic check(input string req, input logic [AW-1:0] exp);
    checks++;
    if (addr_out !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, addr_out, exp);
    end
  endtask

  task automatic step(input logic en, input logic a, input logic [AW-1:0] b, input logic il);
    clk_en = en; adv = a; base_addr = b; order_il = il;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset();
    check("R8 reset zero", '0);
    step(1'b1, 1'b1, 20'hFFFFF, 1'b1);
    check("R8 linear before first load", 20'h00001);
  endtask

  task automatic t_sweep(input logic il);
    for (int s = 0; s < 4; s++) begin
      logic [AW-1:0] b;
      b = {18'h2A5C3, s[1:0]};
      step(1'b1, 1'b0, b, il);
      check("R1 load", b);
      for (int k = 1; k <= 9; k++) begin
        step(1'b1, 1'b1, 20'h0, il);
        check(il ? "R3 interleaved beat" : "R2 linear beat",
              {b[AW-1:2], ref_low(b[1:0], k, il)});
        if (k % 4 == 0) check("R4 wrap", b);
        check("R5 upper held", {b[AW-1:2], addr_out[1:0]});
      end
    end
  endtask

  task automatic t_hold();
    logic [AW-1:0] b;
    b = 20'h12342;
    step(1'b1, 1'b0, b, 1'b1);
    step(1'b1, 1'b1, 20'h0, 1'b1);
    check("R3 beat1", {b[AW-1:2], 2'b11});
    step(1'b0, 1'b1, 20'h0, 1'b0);
    check("R6 hold on advance", {b[AW-1:2], 2'b11});
    step(1'b0, 1'b0, 20'hFFFFF, 1'b0);
    check("R6 hold on load", {b[AW-1:2], 2'b11});
    step(1'b1, 1'b1, 20'h0, 1'b1);
    check("R6 resumes beat2", {b[AW-1:2], 2'b00});
  endtask

  task automatic t_order_change();
    logic [AW-1:0] b;
    b = 20'hABCD1;
    step(1'b1, 1'b0, b, 1'b0);
    step(1'b1, 1'b1, 20'h0, 1'b1);
    check("R7 linear kept", {b[AW-1:2], 2'b10});
    step(1'b1, 1'b1, 20'h0, 1'b1);
    check("R7 linear kept", {b[AW-1:2], 2'b11});
    step(1'b1, 1'b0, b, 1'b1);
    step(1'b1, 1'b1, 20'h0, 1'b0);
    check("R7 interleave kept", {b[AW-1:2], 2'b00});
    step(1'b1, 1'b1, 20'h0, 1'b0);
    check("R7 interleave kept", {b[AW-1:2], 2'b11});
  endtask

  initial begin
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_sweep(1'b0);
    t_sweep(1'b1);
    t_hold();
    t_order_change();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule